// File: doc/BRIEF.md
# AC-link input frame serializer

This block is the codec-side transmitter of the serial return stream on an AC-link. It runs on the bit clock. It samples the frame sync on the falling edge. On the rising edge after it sees sync go from low to high, it starts a 256-bit frame. The frame is a 16-bit tag slot followed by twelve 20-bit slots, sent MSB first, one bit per bit-clock rising edge. The controller samples each bit on the falling edge.

The register port posts a read-back (register index and read data) with a one-cycle request pulse. The converter side posts a left/right sample pair with a one-cycle strobe. Each posted item is held until the next frame start. At that start it is copied into a frame snapshot and cleared, so a read-back or sample pair appears in exactly one frame. The tag slot carries the codec-ready flag and one valid flag for each slot in use. Every position that carries nothing is sent as 0. When codec-ready is low at the frame start, the whole frame is zero.

The sequencer has seven named states. `ST_IDLE` goes to `ST_TAG` on a frame start. The others advance in a fixed chain: `ST_TAG` (16 bits), `ST_ADDR` (20), `ST_DATA` (20), `ST_LEFT` (20), `ST_RIGHT` (20), `ST_FILL` (160 bits for slots 5 to 12), then back to `ST_IDLE`. A frame start in any state goes to `ST_TAG` and restarts the frame.

Top module: `ac_link_in_serializer`

## Requirements
- R1: Sync is sampled on the falling bit-clock edge. The rising edge after a falling edge that sees sync change from 0 to 1 drives tag bit 15, which equals `codec_ready` at that rising edge. Each later bit is driven on the next rising edge.
- R2: A frame is 16 tag bits then twelve 20-bit slots, MSB first, 256 bits in all. After the last bit, `sdata` stays 0 until the next frame start.
- R3: The tag slot has bit 15 = codec-ready, bit 14 = slot 1 valid, bit 13 = slot 2 valid, bit 12 = slot 3 valid, bit 11 = slot 4 valid, and bits 10:0 = 0.
- R4: Slot 1 has bit 19 = 0, bits 18:12 = the read-back register index, and bits 11:0 = 0. It is all zero when no read-back is sent.
- R5: Slot 2 has bits 19:4 = the read data and bits 3:0 = 0. It is all zero when no read-back is sent.
- R6: A read-back posted before a frame start is sent, and flagged valid, only in the frame that follows that start. Later frames carry no read-back.
- R7: Slots 3 and 4 carry the left and right 20-bit samples, flagged valid, when a strobe has occurred since the previous frame start. Otherwise they are zero with their flags at 0.
- R8: Slots 5 to 12 are always all zero.
- R9: If `codec_ready` is 0 at the frame start, the entire frame is zero. Any posted read-back or sample pair is still consumed and does not appear in a later frame.
- R10: A new 0-to-1 sync transition during a frame restarts the frame from tag bit 15. Sync held high does not restart the frame.
- R11: While reset is asserted and after it is released, `sdata` is 0 until a frame starts, and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | Frame sync from the controller |
| codec_ready | input | 1 | Codec ready status |
| rd_req | input | 1 | One-cycle pulse that posts a read-back |
| rd_idx | input | 7 | Register index to echo |
| rd_data | input | 16 | Register read data |
| adc_strobe | input | 1 | One-cycle pulse that posts a sample pair |
| adc_left | input | 20 | Left sample |
| adc_right | input | 20 | Right sample |
| sdata | output | 1 | Serial input-frame data to the controller |

## Verification
Some properties are checked by assertions on every cycle:
- The first bit after a detected start equals the ready level.
- A start always lands in the tag state.
- The idle state, the stuffed slots and any unready frame drive only zeros.
- The address slot is entered only from the tag state.

Other properties can only be shown by the bench scenarios:
- The field placement in each slot.
- The one-frame lifetime of a read-back.
- The consumption of posted items in an unready frame.
- The restart on a mid-frame sync.

// File: rtl/ac_in_pkg.sv
package ac_in_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG,
        ST_ADDR,
        ST_DATA,
        ST_LEFT,
        ST_RIGHT,
        ST_FILL
    } frame_st_t;

endpackage

// File: rtl/ac_in_sync_detect.sv
// Samples sync on the falling edge and flags a frame start on the next rising edge.
module ac_in_sync_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sync,
    output logic start
);
    logic seen_fall;
    logic seen_rise;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) seen_fall <= 1'b0;
        else        seen_fall <= sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_rise <= 1'b0;
        else        seen_rise <= seen_fall;
    end

    assign start = seen_fall & ~seen_rise;
endmodule

// File: rtl/ac_in_frame_seq.sv
// Frame sequencer: state plus down-counter over the bits of the current slot.
module ac_in_frame_seq
    import ac_in_pkg::*;
#(
    parameter int TAG_BITS   = 16,
    parameter int SLOT_BITS  = 20,
    parameter int FILL_SLOTS = 8,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output frame_st_t        st,
    output logic [CNT_W-1:0] pos
);
    localparam logic [CNT_W-1:0] TAG_LAST  = CNT_W'(TAG_BITS - 1);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_BITS - 1);
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(FILL_SLOTS * SLOT_BITS - 1);

    frame_st_t        st_n;
    logic [CNT_W-1:0] pos_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            pos <= '0;
        end else begin
            st  <= st_n;
            pos <= pos_n;
        end
    end

    always_comb begin
        st_n  = st;
        pos_n = pos;
        if (start) begin
            st_n  = ST_TAG;
            pos_n = TAG_LAST;
        end else if (st != ST_IDLE && pos != '0) begin
            pos_n = pos - 1'b1;
        end else begin
            unique case (st)
                ST_IDLE:  begin st_n = ST_IDLE;  pos_n = '0;        end
                ST_TAG:   begin st_n = ST_ADDR;  pos_n = SLOT_LAST; end
                ST_ADDR:  begin st_n = ST_DATA;  pos_n = SLOT_LAST; end
                ST_DATA:  begin st_n = ST_LEFT;  pos_n = SLOT_LAST; end
                ST_LEFT:  begin st_n = ST_RIGHT; pos_n = SLOT_LAST; end
                ST_RIGHT: begin st_n = ST_FILL;  pos_n = FILL_LAST; end
                ST_FILL:  begin st_n = ST_IDLE;  pos_n = '0;        end
                default:  begin st_n = ST_IDLE;  pos_n = '0;        end
            endcase
        end
    end
endmodule

// File: rtl/ac_in_capture.sv
// Holds posted read-back and sample pair; copies them into the frame snapshot at start.
module ac_in_capture #(
    parameter int IDX_W     = 7,
    parameter int REG_W     = 16,
    parameter int SLOT_BITS = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 codec_ready,
    input  logic                 rd_req,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [REG_W-1:0]     rd_data,
    input  logic                 adc_strobe,
    input  logic [SLOT_BITS-1:0] adc_left,
    input  logic [SLOT_BITS-1:0] adc_right,
    output logic                 snap_ready,
    output logic                 snap_rd_vld,
    output logic [IDX_W-1:0]     snap_idx,
    output logic [REG_W-1:0]     snap_data,
    output logic                 snap_adc_vld,
    output logic [SLOT_BITS-1:0] snap_left,
    output logic [SLOT_BITS-1:0] snap_right
);
    logic                 pend_rd;
    logic                 pend_adc;
    logic [IDX_W-1:0]     pend_idx;
    logic [REG_W-1:0]     pend_data;
    logic [SLOT_BITS-1:0] pend_left;
    logic [SLOT_BITS-1:0] pend_right;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_rd      <= 1'b0;
            pend_adc     <= 1'b0;
            pend_idx     <= '0;
            pend_data    <= '0;
            pend_left    <= '0;
            pend_right   <= '0;
            snap_ready   <= 1'b0;
            snap_rd_vld  <= 1'b0;
            snap_idx     <= '0;
            snap_data    <= '0;
            snap_adc_vld <= 1'b0;
            snap_left    <= '0;
            snap_right   <= '0;
        end else begin
            if (start) begin
                snap_ready   <= codec_ready;
                snap_rd_vld  <= codec_ready & pend_rd;
                snap_idx     <= pend_idx;
                snap_data    <= pend_data;
                snap_adc_vld <= codec_ready & pend_adc;
                snap_left    <= pend_left;
                snap_right   <= pend_right;
            end
            if (rd_req) begin
                pend_idx  <= rd_idx;
                pend_data <= rd_data;
            end
            if (adc_strobe) begin
                pend_left  <= adc_left;
                pend_right <= adc_right;
            end
            pend_rd  <= rd_req | (pend_rd & ~start);
            pend_adc <= adc_strobe | (pend_adc & ~start);
        end
    end
endmodule

// File: rtl/ac_in_slot_mux.sv
// Picks the bit driven on the serial line from the state, bit position and snapshot.
module ac_in_slot_mux
    import ac_in_pkg::*;
#(
    parameter int TAG_BITS  = 16,
    parameter int SLOT_BITS = 20,
    parameter int IDX_W     = 7,
    parameter int REG_W     = 16,
    parameter int CNT_W     = 8
) (
    input  frame_st_t            st,
    input  logic [CNT_W-1:0]     pos,
    input  logic                 snap_ready,
    input  logic                 snap_rd_vld,
    input  logic [IDX_W-1:0]     snap_idx,
    input  logic [REG_W-1:0]     snap_data,
    input  logic                 snap_adc_vld,
    input  logic [SLOT_BITS-1:0] snap_left,
    input  logic [SLOT_BITS-1:0] snap_right,
    output logic                 sdata
);
    localparam int TAG_IDX_W  = $clog2(TAG_BITS);
    localparam int SLOT_IDX_W = $clog2(SLOT_BITS);

    logic [TAG_BITS-1:0]  tag_word;
    logic [SLOT_BITS-1:0] addr_word;
    logic [SLOT_BITS-1:0] data_word;
    logic [SLOT_BITS-1:0] left_word;
    logic [SLOT_BITS-1:0] right_word;

    assign tag_word   = {snap_ready, snap_rd_vld, snap_rd_vld, snap_adc_vld, snap_adc_vld,
                         {(TAG_BITS - 5){1'b0}}};
    assign addr_word  = {1'b0, snap_idx, {(SLOT_BITS - 1 - IDX_W){1'b0}}} & {SLOT_BITS{snap_rd_vld}};
    assign data_word  = {snap_data, {(SLOT_BITS - REG_W){1'b0}}} & {SLOT_BITS{snap_rd_vld}};
    assign left_word  = snap_left  & {SLOT_BITS{snap_adc_vld}};
    assign right_word = snap_right & {SLOT_BITS{snap_adc_vld}};

    always_comb begin
        unique case (st)
            ST_IDLE:  sdata = 1'b0;
            ST_TAG:   sdata = tag_word[pos[TAG_IDX_W-1:0]];
            ST_ADDR:  sdata = addr_word[pos[SLOT_IDX_W-1:0]];
            ST_DATA:  sdata = data_word[pos[SLOT_IDX_W-1:0]];
            ST_LEFT:  sdata = left_word[pos[SLOT_IDX_W-1:0]];
            ST_RIGHT: sdata = right_word[pos[SLOT_IDX_W-1:0]];
            ST_FILL:  sdata = 1'b0;
            default:  sdata = 1'b0;
        endcase
    end
endmodule

// File: rtl/ac_link_in_serializer.sv
module ac_link_in_serializer
    import ac_in_pkg::*;
#(
    parameter int TAG_BITS  = 16,
    parameter int SLOT_BITS = 20,
    parameter int NUM_SLOTS = 12,
    parameter int IDX_W     = 7,
    parameter int REG_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync,
    input  logic                 codec_ready,
    input  logic                 rd_req,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic [REG_W-1:0]     rd_data,
    input  logic                 adc_strobe,
    input  logic [SLOT_BITS-1:0] adc_left,
    input  logic [SLOT_BITS-1:0] adc_right,
    output logic                 sdata
);
    localparam int FILL_SLOTS = NUM_SLOTS - 4;
    localparam int FILL_LEN   = FILL_SLOTS * SLOT_BITS;
    localparam int CNT_W      = $clog2(FILL_LEN);

    logic                 start_w;
    frame_st_t            st_w;
    logic [CNT_W-1:0]     pos_w;
    logic                 snap_ready_w;
    logic                 snap_rd_vld_w;
    logic [IDX_W-1:0]     snap_idx_w;
    logic [REG_W-1:0]     snap_data_w;
    logic                 snap_adc_vld_w;
    logic [SLOT_BITS-1:0] snap_left_w;
    logic [SLOT_BITS-1:0] snap_right_w;

    ac_in_sync_detect u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .sync  (sync),
        .start (start_w)
    );

    ac_in_frame_seq #(
        .TAG_BITS   (TAG_BITS),
        .SLOT_BITS  (SLOT_BITS),
        .FILL_SLOTS (FILL_SLOTS),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_w),
        .st    (st_w),
        .pos   (pos_w)
    );

    ac_in_capture #(
        .IDX_W     (IDX_W),
        .REG_W     (REG_W),
        .SLOT_BITS (SLOT_BITS)
    ) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start_w),
        .codec_ready  (codec_ready),
        .rd_req       (rd_req),
        .rd_idx       (rd_idx),
        .rd_data      (rd_data),
        .adc_strobe   (adc_strobe),
        .adc_left     (adc_left),
        .adc_right    (adc_right),
        .snap_ready   (snap_ready_w),
        .snap_rd_vld  (snap_rd_vld_w),
        .snap_idx     (snap_idx_w),
        .snap_data    (snap_data_w),
        .snap_adc_vld (snap_adc_vld_w),
        .snap_left    (snap_left_w),
        .snap_right   (snap_right_w)
    );

    ac_in_slot_mux #(
        .TAG_BITS  (TAG_BITS),
        .SLOT_BITS (SLOT_BITS),
        .IDX_W     (IDX_W),
        .REG_W     (REG_W),
        .CNT_W     (CNT_W)
    ) u_mux (
        .st           (st_w),
        .pos          (pos_w),
        .snap_ready   (snap_ready_w),
        .snap_rd_vld  (snap_rd_vld_w),
        .snap_idx     (snap_idx_w),
        .snap_data    (snap_data_w),
        .snap_adc_vld (snap_adc_vld_w),
        .snap_left    (snap_left_w),
        .snap_right   (snap_right_w),
        .sdata        (sdata)
    );
endmodule

// File: rtl/ac_in_checker.sv
module ac_in_checker
    import ac_in_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      codec_ready,
    input logic      sdata,
    input logic      start,
    input frame_st_t st,
    input logic      snap_ready
);
    p_first_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (sdata == $past(codec_ready)));

    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st == ST_TAG));

    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sdata);

    p_addr_after_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR && $past(st) != ST_ADDR) |-> ($past(st) == ST_TAG));

    p_fill_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL) |-> !sdata);

    p_unready_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !snap_ready) |-> !sdata);
endmodule

bind ac_link_in_serializer ac_in_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .codec_ready (codec_ready),
    .sdata       (sdata),
    .start       (start_w),
    .st          (st_w),
    .snap_ready  (snap_ready_w)
);

// File: tb/test_ac_link_in_serializer.sv
`timescale 1ns/1ps
module test_ac_link_in_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        codec_ready = 1'b0;
    logic        rd_req = 1'b0;
    logic [6:0]  rd_idx = '0;
    logic [15:0] rd_data = '0;
    logic        adc_strobe = 1'b0;
    logic [19:0] adc_left = '0;
    logic [19:0] adc_right = '0;
    logic        sdata;

    int n_chk = 0;
    int n_fail = 0;

    // bench model of pending items
    logic        m_ready = 1'b0;
    logic        m_rd_pend = 1'b0;
    logic [6:0]  m_idx = '0;
    logic [15:0] m_data = '0;
    logic        m_adc_pend = 1'b0;
    logic [19:0] m_l = '0;
    logic [19:0] m_r = '0;

    logic [19:0] exp_q[$];
    string       lbl_q[$];
    event        frame_go;

    always #10 clk = ~clk;

    ac_link_in_serializer i_ac_link_in_serializer (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync        (sync),
        .codec_ready (codec_ready),
        .rd_req      (rd_req),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data),
        .adc_strobe  (adc_strobe),
        .adc_left    (adc_left),
        .adc_right   (adc_right),
        .sdata       (sdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // consume model pending state; optionally push expected slot words
    task automatic gen_expect(input string label, input bit track);
        logic rdv, adv;
        rdv = m_ready & m_rd_pend;
        adv = m_ready & m_adc_pend;
        if (track) begin
            lbl_q.push_back(label);
            exp_q.push_back({4'b0, m_ready, rdv, rdv, adv, adv, 11'b0});
            exp_q.push_back(rdv ? {1'b0, m_idx, 12'b0} : 20'h0);
            exp_q.push_back(rdv ? {m_data, 4'b0} : 20'h0);
            exp_q.push_back(adv ? m_l : 20'h0);
            exp_q.push_back(adv ? m_r : 20'h0);
            for (int s = 5; s <= 12; s++) exp_q.push_back(20'h0);
        end
        m_rd_pend  = 1'b0;
        m_adc_pend = 1'b0;
    endtask

    task automatic do_read(input logic [6:0] idx, input logic [15:0] data);
        @(posedge clk); #2;
        rd_req = 1'b1; rd_idx = idx; rd_data = data;
        @(posedge clk); #2;
        rd_req = 1'b0;
        m_rd_pend = 1'b1; m_idx = idx; m_data = data;
    endtask

    task automatic do_adc(input logic [19:0] l, input logic [19:0] r);
        @(posedge clk); #2;
        adc_strobe = 1'b1; adc_left = l; adc_right = r;
        @(posedge clk); #2;
        adc_strobe = 1'b0;
        m_adc_pend = 1'b1; m_l = l; m_r = r;
    endtask

    task automatic set_ready(input logic v);
        @(posedge clk); #2;
        codec_ready = v;
        m_ready = v;
    endtask

    task automatic send_frame(input string label);
        @(posedge clk); #2;
        gen_expect(label, 1'b1);
        sync = 1'b1;
        -> frame_go;
        repeat (16) @(posedge clk);
        #2 sync = 1'b0;
        repeat (250) @(posedge clk);
    endtask

    // monitor: pops expected slot words and compares against the serial stream
    initial begin
        forever begin
            string lbl;
            @(frame_go);
            lbl = lbl_q.pop_front();
            @(negedge clk);
            for (int s = 0; s <= 12; s++) begin
                logic [19:0] got;
                logic [19:0] exp;
                string req;
                int w;
                w = (s == 0) ? 16 : 20;
                got = '0;
                for (int b = 0; b < w; b++) begin
                    @(negedge clk);
                    got = {got[18:0], sdata};
                end
                exp = exp_q.pop_front();
                if (s == 0)      req = "R1 R3";
                else if (s == 1) req = "R4";
                else if (s == 2) req = "R5";
                else if (s <= 4) req = "R7";
                else             req = "R8";
                chk(got == exp, req, $sformatf("%s slot %0d", lbl, s), {12'b0, got}, {12'b0, exp});
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk(sdata == 1'b0, "R11", "sdata in reset", {31'b0, sdata}, 32'h0);
        @(posedge clk); #2 rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(sdata == 1'b0, "R11", "sdata after reset", {31'b0, sdata}, 32'h0);

        set_ready(1'b1);
        send_frame("R3 plain frame");

        do_read(7'h2A, 16'hBEEF);
        do_adc(20'hABCDE, 20'h12345);
        send_frame("R6 read and samples");
        send_frame("R6 follow-up frame");

        // R2: line stays low after the last bit
        begin
            bit quiet;
            quiet = 1'b1;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (sdata !== 1'b0) quiet = 1'b0;
            end
            chk(quiet, "R2", "idle after frame", {31'b0, ~quiet}, 32'h0);
        end

        do_read(7'h11, 16'h1234);
        do_adc(20'hFFFFF, 20'h00001);
        set_ready(1'b0);
        send_frame("R9 unready frame");
        set_ready(1'b1);
        send_frame("R9 consumed items");

        do_read(7'h7F, 16'hFFFF);
        send_frame("R4 read only max index");

        // R10: resync mid-frame; first frame untracked
        do_read(7'h05, 16'h0A0A);
        @(posedge clk); #2;
        gen_expect("", 1'b0);
        sync = 1'b1;
        repeat (16) @(posedge clk);
        #2 sync = 1'b0;
        do_adc(20'h5A5A5, 20'hA5A5A);
        repeat (20) @(posedge clk);
        send_frame("R10 resync frame");

        summary();
        $finish;
    end
endmodule